// File: doc/BRIEF.md
# Protection Region Attribute Matcher

This block keeps the attribute and size word of one memory protection region and classifies each access presented to it. Software loads a 32-bit configuration word that holds a region enable, a power-of-two size exponent, an eight-bit mask that can switch off individual eighths of the region, a three-bit permission code, three cache-policy bits and an execute-never flag. The region base address arrives on its own input. It is aligned to the region size, so its low bits are not used.

On every clock edge the block takes the access address and an instruction-fetch flag. One cycle later it reports three flags. The first is a region hit. The second says the access landed in a subregion that has been switched off. The third says an instruction fetch was refused because the region is marked execute-never. Checking the permission code against privilege, and choosing between overlapping regions, are left to the logic around the block.

Top module: `region_attr_matcher`

## Requirements
- R1: After reset the configuration read-back `cfgRdata` is 0 and `hit`, `subOff` and `fetchDenied` are 0, so the region starts disabled.
- R2: A write stores only the defined fields: enable at bit 0, size code at bits 5:1, subregion-off mask at bits 15:8, cache-policy bits at 18:16, permission code at 26:24 and execute-never at bit 28. All other bits read back as 0, and a write is visible on `cfgRdata` from the next cycle.
- R3: With the enable bit at 0 the block never reports `hit` or `subOff`.
- R4: With the region enabled and size code S (7 to 31), an address whose bits 31 down to S+1 equal those of `baseAddr` hits. The result appears on the outputs one cycle after the address is sampled. An address outside that range misses.
- R5: Bits S down to 0 of `baseAddr` are ignored.
- R6: A size code below 7 makes the region never hit and never report `subOff`. A size code of 7 (a 256-byte region) works normally.
- R7: A size code of 31 makes the region cover every address.
- R8: Address bits S down to S-2 pick a mask bit. If that bit is 1, the access gives `hit` = 0 and `subOff` = 1. If it is 0, the access gives a normal hit.
- R9: `fetchDenied` is 1 exactly when the access hits, `accFetch` was 1 and execute-never is 1. When execute-never is 0, fetches are never denied.
- R10: `subOff` is raised only when the region is enabled and the upper address bits match the base. An address outside the region gives 0 on all three flags, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the configuration word |
| cfgWdata | input | 32 | Configuration word to store |
| cfgRdata | output | 32 | Stored configuration, with undefined bits reading 0 |
| baseAddr | input | 32 | Region base address |
| accAddr | input | 32 | Access address, sampled every cycle |
| accFetch | input | 1 | The access is an instruction fetch |
| hit | output | 1 | The access hit an active part of the region |
| subOff | output | 1 | The access fell in a switched-off subregion |
| fetchDenied | output | 1 | An instruction fetch was refused because of execute-never |

## Verification
Each access result is registered. The flags for an address sampled at one rising edge are valid from that edge until the next one. A configuration write becomes visible on `cfgRdata` after the same single edge, and from then on it governs every access sampled afterwards. The bench therefore writes the configuration on one edge, presents the address at the following falling edge, and compares all three flags at the falling edge after the next rising edge. The checker's properties use the same one-cycle offset: they compare each flag against the configuration and fetch input as they stood one cycle earlier.

// File: rtl/region_attr_pkg.sv
package region_attr_pkg;

  localparam int ADDR_W   = 32;
  localparam int SUB_BITS = 3;
  localparam int SUB_CNT  = 1 << SUB_BITS;
  localparam int MIN_SIZE = 7;

  localparam int EN_BIT   = 0;
  localparam int SIZE_LO  = 1;
  localparam int SIZE_HI  = 5;
  localparam int MASK_LO  = 8;
  localparam int MASK_HI  = MASK_LO + SUB_CNT - 1;
  localparam int POL_LO   = 16;
  localparam int POL_HI   = 18;
  localparam int PERM_LO  = 24;
  localparam int PERM_HI  = 26;
  localparam int XN_BIT   = 28;

  localparam logic [31:0] WRITABLE = 32'h1707_FF3F;

  typedef struct packed {
    logic loadCfg;
    logic regionLive;
  } ctrl_strobe_t;

endpackage

// File: rtl/region_attr_ctrl.sv
module region_attr_ctrl
  import region_attr_pkg::*;
#(
  parameter int MinSize = MIN_SIZE
) (
  input  logic         cfgWrEn,
  input  logic         enableBit,
  input  logic [4:0]   sizeCode,
  output ctrl_strobe_t strobe
);

  localparam logic [4:0] MinCode = 5'(MinSize);

  logic sizeLegal;

  always_comb begin
    sizeLegal         = (sizeCode >= MinCode);
    strobe.loadCfg    = cfgWrEn;
    strobe.regionLive = enableBit && sizeLegal;
  end

endmodule

// File: rtl/region_attr_dp.sv
module region_attr_dp
  import region_attr_pkg::*;
#(
  parameter int AddrW   = ADDR_W,
  parameter int SubBits = SUB_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [31:0]       cfgWdata,
  input  logic [AddrW-1:0]  baseAddr,
  input  logic [AddrW-1:0]  accAddr,
  input  logic              accFetch,
  output logic [31:0]       cfgWord,
  output logic              hit,
  output logic              subOff,
  output logic              fetchDenied
);

  localparam int SubCnt = 1 << SubBits;
  localparam int IdxW   = $clog2(AddrW + 1) + 1;

  logic [31:0]        cfgReg;
  logic [4:0]         sizeCode;
  logic [IdxW-1:0]    nBits;
  logic [IdxW-1:0]    shiftAmt;
  logic [AddrW-1:0]   keepMask;
  logic [AddrW-1:0]   shifted;
  logic [SubBits-1:0] subIdx;
  logic [SubCnt-1:0]  offMask;
  logic               upperMatch;
  logic               maskedOff;
  logic               xnFlag;
  logic               hitNext;
  logic               subNext;
  logic               denyNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (strobe.loadCfg) begin
      cfgReg <= cfgWdata & WRITABLE;
    end
  end

  assign cfgWord  = cfgReg;
  assign sizeCode = cfgReg[SIZE_HI:SIZE_LO];
  assign offMask  = cfgReg[MASK_HI:MASK_LO];
  assign xnFlag   = cfgReg[XN_BIT];
  assign nBits    = IdxW'(sizeCode) + IdxW'(1);
  assign shiftAmt = nBits - IdxW'(SubBits);

  for (genvar g = 0; g < AddrW; g++) begin : g_keep
    assign keepMask[g] = (IdxW'(g) >= nBits);
  end

  always_comb begin
    upperMatch = (((accAddr ^ baseAddr) & keepMask) == '0);
    shifted    = accAddr >> shiftAmt;
    subIdx     = shifted[SubBits-1:0];
    maskedOff  = offMask[subIdx];
    hitNext    = strobe.regionLive && upperMatch && !maskedOff;
    subNext    = strobe.regionLive && upperMatch && maskedOff;
    denyNext   = hitNext && accFetch && xnFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit         <= 1'b0;
      subOff      <= 1'b0;
      fetchDenied <= 1'b0;
    end else begin
      hit         <= hitNext;
      subOff      <= subNext;
      fetchDenied <= denyNext;
    end
  end

endmodule

// File: rtl/region_attr_matcher.sv
module region_attr_matcher
  import region_attr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  input  logic [31:0] baseAddr,
  input  logic [31:0] accAddr,
  input  logic        accFetch,
  output logic        hit,
  output logic        subOff,
  output logic        fetchDenied
);

  ctrl_strobe_t strobe;
  logic [31:0]  cfgWord;

  region_attr_ctrl #(.MinSize(MIN_SIZE)) u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .enableBit (cfgWord[EN_BIT]),
    .sizeCode  (cfgWord[SIZE_HI:SIZE_LO]),
    .strobe    (strobe)
  );

  region_attr_dp #(.AddrW(ADDR_W), .SubBits(SUB_BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgWdata    (cfgWdata),
    .baseAddr    (baseAddr),
    .accAddr     (accAddr),
    .accFetch    (accFetch),
    .cfgWord     (cfgWord),
    .hit         (hit),
    .subOff      (subOff),
    .fetchDenied (fetchDenied)
  );

  assign cfgRdata = cfgWord;

endmodule

// File: rtl/region_attr_checker.sv
module region_attr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [31:0] cfgWdata,
  input logic [31:0] cfgRdata,
  input logic        accFetch,
  input logic        hit,
  input logic        subOff,
  input logic        fetchDenied
);

  localparam logic [31:0] Writable = 32'h1707_FF3F;

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata & ~Writable) == 32'h0);

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdata == ($past(cfgWdata) & Writable));

  p_off_region_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgRdata[0]) |-> (!hit && !subOff));

  p_small_size_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgRdata[5:1]) < 5'd7) |-> (!hit && !subOff));

  p_hit_or_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && subOff));

  p_deny_needs_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    fetchDenied |-> (hit && $past(accFetch) && $past(cfgRdata[28])));

  p_deny_when_due_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hit && $past(accFetch) && $past(cfgRdata[28])) |-> fetchDenied);

endmodule

bind region_attr_matcher region_attr_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWrEn     (cfgWrEn),
  .cfgWdata    (cfgWdata),
  .cfgRdata    (cfgRdata),
  .accFetch    (accFetch),
  .hit         (hit),
  .subOff      (subOff),
  .fetchDenied (fetchDenied)
);

// File: tb/tb_region_attr_matcher.sv
module tb_region_attr_matcher;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] base;
    logic [31:0] addr;
    logic        fetch;
    logic        expHit;
    logic        expOff;
    logic        expDeny;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  // cfg: en bit0, size 5:1, mask 15:8, XN bit28
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0013, 32'h2000_0400, 32'h2000_0400, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 low edge
    '{32'h0000_0013, 32'h2000_0400, 32'h2000_07FC, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 high edge
    '{32'h0000_0013, 32'h2000_0400, 32'h2000_0800, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 above
    '{32'h0000_0013, 32'h2000_0400, 32'h2000_03FC, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 below
    '{32'h0000_0013, 32'h2000_05A4, 32'h2000_0410, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 base low bits
    '{32'h0000_0413, 32'h2000_0400, 32'h2000_0510, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8 eighth 2 off
    '{32'h0000_0413, 32'h2000_0400, 32'h2000_0590, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 eighth 3 on
    '{32'h0000_0012, 32'h2000_0400, 32'h2000_0400, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 disabled
    '{32'h0000_000D, 32'h2000_0400, 32'h2000_0400, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 size 6
    '{32'h0000_003F, 32'h1234_5678, 32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 full space
    '{32'h0000_803F, 32'h1234_5678, 32'hF000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8 top eighth, size 31
    '{32'h1000_0013, 32'h2000_0400, 32'h2000_0400, 1'b1, 1'b1, 1'b0, 1'b1, 8'd9},  // R9 XN fetch
    '{32'h1000_0013, 32'h2000_0400, 32'h2000_0400, 1'b0, 1'b1, 1'b0, 1'b0, 8'd9},  // R9 XN data
    '{32'h0000_0013, 32'h2000_0400, 32'h2000_0400, 1'b1, 1'b1, 1'b0, 1'b0, 8'd9},  // R9 no XN fetch
    '{32'h1000_FF13, 32'h2000_0400, 32'h3000_0400, 1'b1, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 outside
    '{32'h0000_000F, 32'h0000_0100, 32'h0000_01FF, 1'b0, 1'b1, 1'b0, 1'b0, 8'd6}   // R6 size 7 works
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic [31:0] baseAddr = '0;
  logic [31:0] accAddr = '0;
  logic        accFetch = 1'b0;
  logic        hit;
  logic        subOff;
  logic        fetchDenied;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_attr_matcher dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .baseAddr(baseAddr), .accAddr(accAddr),
    .accFetch(accFetch), .hit(hit), .subOff(subOff), .fetchDenied(fetchDenied)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    cfgWrEn  = 1'b1;
    cfgWdata = v.cfg;
    @(negedge clk);
    cfgWrEn  = 1'b0;
    baseAddr = v.base;
    accAddr  = v.addr;
    accFetch = v.fetch;
    @(negedge clk);
    check(tag, "hit", 32'(hit), 32'(v.expHit));
    check(tag, "subOff", 32'(subOff), 32'(v.expOff));
    check(tag, "fetchDenied", 32'(fetchDenied), 32'(v.expDeny));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "cfgRdata", cfgRdata, 32'h0);
    check("R1", "hit", 32'(hit), 32'h0);
    check("R1", "subOff", 32'(subOff), 32'h0);
    rstN = 1'b1;
    // R1 region starts disabled: address equal to base gives no hit
    baseAddr = 32'h0;
    accAddr  = 32'h0;
    @(negedge clk);
    @(negedge clk);
    check("R1", "hit after reset", 32'(hit), 32'h0);

    // R2 reserved bits drop, write seen next cycle
    cfgWrEn  = 1'b1;
    cfgWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfgWrEn  = 1'b0;
    check("R2", "cfgRdata all ones", cfgRdata, 32'h1707_FF3F);
    cfgWrEn  = 1'b1;
    cfgWdata = 32'hE8F8_00C0;
    @(negedge clk);
    cfgWrEn  = 1'b0;
    check("R2", "cfgRdata reserved only", cfgRdata, 32'h0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R8 every eighth of a 1 KB region, one mask bit off at a time
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cfgWrEn  = 1'b1;
      cfgWdata = 32'h0000_0013 | (32'h100 << k);
      @(negedge clk);
      cfgWrEn  = 1'b0;
      baseAddr = 32'h4000_0000;
      accAddr  = 32'h4000_0000 + 32'(k * 128) + 32'd4;
      @(negedge clk);
      check("R8", "swept hit", 32'(hit), 32'h0);
      check("R8", "swept subOff", 32'(subOff), 32'h1);
      accAddr = 32'h4000_0000 + 32'(((k + 1) % 8) * 128);
      @(negedge clk);
      check("R8", "neighbour hit", 32'(hit), 32'h1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule